// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This peripheral is a countdown watchdog whose control word cannot be changed by a single stray store. Software first writes a control word whose key byte (bits 23:16) holds 0xBE. The next control write must carry key 0xDC, and it carries the whole configuration in the same word: the enable flag, the prescale select and a 16-bit reload value. An accepted second write with enable set loads the counter and restarts the prescaler. Repeating the pair in this way is the keepalive, and it is also how a new timeout is applied. An accepted second write with enable clear stops the watchdog.

While the watchdog is enabled, a prescaler divides the I/O clock. Its ratio is picked from four parameterised powers of two, and each prescaler tick lowers the counter by one. If the counter sits at zero while the watchdog is enabled, a sticky reset-request output is raised. Only the module reset clears it. A status word at a separate offset shows the enable flag, the prescale select and the live count.

Top module: `pw_wdt`

## Requirements
- R1: After reset the enable flag, prescale select, count and reset request are all zero, and a status read returns 0.
- R2: A write to the control offset (0x0) with key 0xBE in bits 23:16 arms the sequence. The next control write with key 0xDC applies bit 31 as enable, bits 25:24 as prescale select and bits 15:0 as reload. Bits 30:26 are ignored.
- R3: A control write whose key does not match the current step is ignored and returns the sequence to idle. A 0xDC write that does not follow an armed state applies nothing.
- R4: A write to any address other than the control offset, including the status offset 0x8, leaves the unlock state unchanged.
- R5: While enabled and nonzero, the count drops by exactly one every 2^SHIFTn clocks, where n is the prescale select (defaults 1, 64, 4096, 262144).
- R6: An applied write with enable set loads the count with the reload value and restarts the prescale phase at once. This is the keepalive.
- R7: When the watchdog is enabled, the count is zero and no write is applied in that cycle, rst_req_o rises on the next edge. It then stays high until reset.
- R8: An applied write with enable clear stops counting and leaves the count frozen at its last value.
- R9: A read (rd_i high) at offset 0x8 returns enable in bit 31, prescale select in bits 25:24 and count in bits 15:0, with zeros elsewhere. Any other read returns 0.
- R10: If a keepalive is applied in the same cycle that the count is zero or a tick is due, the reload wins and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The critical overlap is a keepalive landing in the very cycle the counter reaches zero, or in a cycle where a prescaler tick is due. The bench times a sequence with reload 3 at a prescale of 1 so that the second key write samples exactly when the count is zero. It then expects the new reload in the status word and no reset request. A behavioural reference model checks the status word and rst_req_o on every clock across all four prescale settings, bad-key sequences and interleaved writes to other addresses.

// File: rtl/pw_wdt_pkg.sv
package pw_wdt_pkg;
  typedef enum logic {ULK_IDLE = 1'b0, ULK_ARMED = 1'b1} ulk_state_e;

  localparam int CNT_W = 16;

  typedef struct packed {
    logic             en;
    logic [1:0]       sel;
    logic [CNT_W-1:0] reload;
  } wdt_cfg_t;
endpackage

// File: rtl/pw_wdt_unlock.sv
module pw_wdt_unlock
  import pw_wdt_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFF = '0,
  parameter logic [7:0]      KEY1     = 8'hBE,
  parameter logic [7:0]      KEY2     = 8'hDC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              apply_o,
  output wdt_cfg_t          cfg_o
);
  ulk_state_e state_q, state_d;
  logic       ctrl_wr;
  logic [7:0] key;
  logic       unused_bits;

  assign ctrl_wr = wr_i && (addr_i == CTRL_OFF);
  assign key     = wdata_i[23:16];
  assign unused_bits = ^wdata_i[30:26];

  always_comb begin
    state_d = state_q;
    if (ctrl_wr) begin
      if (state_q == ULK_IDLE) state_d = (key == KEY1) ? ULK_ARMED : ULK_IDLE;
      else                     state_d = ULK_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ULK_IDLE;
    else         state_q <= state_d;
  end

  assign apply_o       = ctrl_wr && (state_q == ULK_ARMED) && (key == KEY2);
  assign cfg_o.en      = wdata_i[31];
  assign cfg_o.sel     = wdata_i[25:24];
  assign cfg_o.reload  = wdata_i[CNT_W-1:0];

  // R4
  other_addr_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> state_q == $past(state_q));
  // R3
  armed_always_exits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && state_q == ULK_ARMED) |=> state_q == ULK_IDLE);
endmodule

// File: rtl/pw_wdt_prescale.sv
module pw_wdt_prescale #(
  parameter int SHIFT0 = 0,
  parameter int SHIFT1 = 6,
  parameter int SHIFT2 = 12,
  parameter int SHIFT3 = 18
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int M01  = (SHIFT0 > SHIFT1) ? SHIFT0 : SHIFT1;
  localparam int M23  = (SHIFT2 > SHIFT3) ? SHIFT2 : SHIFT3;
  localparam int MAXS = (M01 > M23) ? M01 : M23;
  localparam int PW   = (MAXS > 0) ? MAXS : 1;

  function automatic int shift_of(input int idx);
    case (idx)
      0:       return SHIFT0;
      1:       return SHIFT1;
      2:       return SHIFT2;
      default: return SHIFT3;
    endcase
  endfunction

  logic [PW-1:0] mask_tab [4];
  logic [PW-1:0] presc_q;

  for (genvar g = 0; g < 4; g++) begin : g_mask
    assign mask_tab[g] = {PW{1'b1}} >> (PW - shift_of(g));
  end

  assign tick_o = run_i && (presc_q == mask_tab[sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            presc_q <= '0;
    else if (restart_i || !run_i || tick_o) presc_q <= '0;
    else                                    presc_q <= presc_q + 1'b1;
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i && sel_i != 2'd0 && mask_tab[sel_i] != '0) |=> !tick_o);
endmodule

// File: rtl/pw_wdt_counter.sv
module pw_wdt_counter
  import pw_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             apply_i,
  input  wdt_cfg_t         cfg_i,
  input  logic             tick_i,
  output logic             en_o,
  output logic [1:0]       sel_o,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_req_o
);
  logic zero;
  assign zero = (count_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      sel_o   <= '0;
      count_o <= '0;
    end else if (apply_i) begin
      en_o  <= cfg_i.en;
      sel_o <= cfg_i.sel;
      if (cfg_i.en) count_o <= cfg_i.reload;
    end else if (en_o && tick_i && !zero) begin
      count_o <= count_o - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rst_req_o <= 1'b0;
    else if (en_o && zero && !apply_i) rst_req_o <= 1'b1;
  end

  // R7
  req_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);
  // R8
  count_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !apply_i) |=> $stable(count_o));
  // R6
  reload_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && cfg_i.en) |=> count_o == $past(cfg_i.reload));
  // R5
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && !apply_i && !zero) |=> (count_o == $past(count_o) || count_o == $past(count_o) - 1'b1));
  // R10
  keepalive_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && cfg_i.en && !rst_req_o) |=> !rst_req_o);
endmodule

// File: rtl/pw_wdt.sv
module pw_wdt
  import pw_wdt_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h0,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h8,
  parameter logic [7:0]        KEY1     = 8'hBE,
  parameter logic [7:0]        KEY2     = 8'hDC,
  parameter int                SHIFT0   = 0,
  parameter int                SHIFT1   = 6,
  parameter int                SHIFT2   = 12,
  parameter int                SHIFT3   = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rst_req_o
);
  logic             apply;
  wdt_cfg_t         cfg;
  logic             tick;
  logic             en;
  logic [1:0]       sel;
  logic [CNT_W-1:0] count;

  pw_wdt_unlock #(
    .ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .KEY1(KEY1), .KEY2(KEY2)
  ) u_unlock (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .apply_o(apply), .cfg_o(cfg)
  );

  pw_wdt_prescale #(
    .SHIFT0(SHIFT0), .SHIFT1(SHIFT1), .SHIFT2(SHIFT2), .SHIFT3(SHIFT3)
  ) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en), .restart_i(apply),
    .sel_i(sel), .tick_o(tick)
  );

  pw_wdt_counter u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .apply_i(apply), .cfg_i(cfg),
    .tick_i(tick), .en_o(en), .sel_o(sel), .count_o(count),
    .rst_req_o(rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && addr_i == STAT_OFF) begin
      rdata_o[31]          = en;
      rdata_o[25:24]       = sel;
      rdata_o[CNT_W-1:0]   = count;
    end
  end
endmodule

// File: tb/pw_wdt_bench.sv
`timescale 1ns/1ps
module pw_wdt_bench;
  localparam int SH0 = 0, SH1 = 1, SH2 = 2, SH3 = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b1;
  logic [3:0]  addr = 4'h8;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_st, m_en, m_div, m_cnt, m_pre, m_req;

  always #10 clk = ~clk;

  pw_wdt #(.SHIFT0(SH0), .SHIFT1(SH1), .SHIFT2(SH2), .SHIFT3(SH3)) u_pw_wdt (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(we), .rd_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(req)
  );

  function automatic int plen(input int d);
    case (d)
      0: return 1 << SH0;
      1: return 1 << SH1;
      2: return 1 << SH2;
      default: return 1 << SH3;
    endcase
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_div = 0; m_cnt = 0; m_pre = 0; m_req = 0;
    end else begin
      automatic bit ap = 0;
      automatic int key = int'(wdata[23:16]);
      if (we && addr == 4'h0) begin
        if (m_st == 0) m_st = (key == 'hBE) ? 1 : 0;
        else begin
          if (key == 'hDC) ap = 1;
          m_st = 0;
        end
      end
      if (ap) begin
        m_en = int'(wdata[31]); m_div = int'(wdata[25:24]);
        if (m_en != 0) begin m_cnt = int'(wdata[15:0]); m_pre = 0; end
      end else if (m_en != 0) begin
        if (m_cnt == 0) m_req = 1;
        else if (m_pre == plen(m_div) - 1) begin m_cnt = m_cnt - 1; m_pre = 0; end
        else m_pre = m_pre + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic logic [31:0] exp_rd = '0;
      if (re && addr == 4'h8) exp_rd = {m_en[0], 5'b0, m_div[1:0], 8'b0, m_cnt[15:0]};
      chk("R9 status vs model", rdata, exp_rd);
      chk("R7 rst_req vs model", {31'b0, req}, {31'b0, m_req[0]});
    end
  end

  function automatic logic [31:0] cfgw(input bit en, input logic [1:0] div, input logic [15:0] rl);
    return {en, 3'b0, 2'b11, div, 8'hDC, rl};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; addr = 4'h8; wdata = '0;
  endtask

  task automatic unlock_apply(input bit en, input logic [1:0] div, input logic [15:0] rl);
    wr(4'h0, 32'h00BE0000);
    wr(4'h0, cfgw(en, div, rl));
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: bench hung");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 status in reset", rdata, 32'h0);
    chk("R1 rst_req in reset", {31'b0, req}, 32'h0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", rdata, 32'h0);

    // R2 basic apply, R6 load
    unlock_apply(1'b1, 2'd2, 16'd10);
    @(negedge clk);
    chk("R2/R6 applied config", rdata, 32'h820A_000A - 32'h000A_0000);
    idle(30);

    // R5 prescale 8 (select 3)
    unlock_apply(1'b1, 2'd3, 16'd3);
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk("R5 before first tick", {16'b0, rdata[15:0]}, 32'd3);
    @(negedge clk);
    chk("R5 after first tick", {16'b0, rdata[15:0]}, 32'd2);

    // R8 disable freezes
    unlock_apply(1'b0, 2'd1, 16'd0);
    @(negedge clk);
    begin
      automatic logic [31:0] snap = rdata;
      chk("R8 enable cleared", {31'b0, rdata[31]}, 32'h0);
      idle(40);
      @(negedge clk);
      chk("R8 count frozen", rdata, snap);
    end

    // R3 bad first key then lone second key
    wr(4'h0, 32'h00AA0000);
    wr(4'h0, cfgw(1'b1, 2'd0, 16'd7));
    @(negedge clk);
    chk("R3 lone second key ignored", {31'b0, rdata[31]}, 32'h0);

    // R3 armed then bad key then second key
    wr(4'h0, 32'h00BE0000);
    wr(4'h0, 32'h00120000);
    wr(4'h0, cfgw(1'b1, 2'd0, 16'd7));
    @(negedge clk);
    chk("R3 bad key drops arming", {31'b0, rdata[31]}, 32'h0);

    // R4 other-address writes between keys
    wr(4'h0, 32'h00BE0000);
    wr(4'h8, 32'h00AA0000);
    wr(4'h4, 32'h0);
    wr(4'h0, cfgw(1'b1, 2'd1, 16'd9));
    @(negedge clk);
    chk("R4 arming survives other writes", rdata, 32'h8100_0009);
    idle(10);

    // R10 keepalive in the zero cycle
    unlock_apply(1'b1, 2'd0, 16'd3);
    unlock_apply(1'b1, 2'd0, 16'd20);
    @(negedge clk);
    chk("R10 reload wins on zero", rdata, 32'h8000_0014);
    chk("R10 no reset request", {31'b0, req}, 32'h0);

    // R7 expiry and stickiness
    unlock_apply(1'b1, 2'd0, 16'd5);
    idle(10);
    @(negedge clk);
    chk("R7 request raised", {31'b0, req}, 32'h1);
    unlock_apply(1'b1, 2'd0, 16'd50);
    @(negedge clk);
    chk("R7 request sticky after keepalive", {31'b0, req}, 32'h1);

    // R9 read gating
    @(posedge clk); #1 re = 1'b0;
    @(negedge clk);
    chk("R9 no read returns zero", rdata, 32'h0);
    #1 re = 1'b1; addr = 4'h0;
    @(negedge clk);
    chk("R9 other offset returns zero", rdata, 32'h0);
    #1 addr = 4'h8;

    // R1 mid-run reset clears request
    do_reset();
    @(negedge clk);
    chk("R1 reset clears request", {31'b0, req}, 32'h0);
    chk("R1 reset clears status", rdata, 32'h0);

    // R5 select 1 run to expiry with model
    unlock_apply(1'b1, 2'd1, 16'd4);
    idle(12);
    @(negedge clk);
    chk("R5 prescale 2 expiry", {31'b0, req}, 32'h1);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule